// File: doc/BRIEF.md
# Keyboard Code and Strobe Latch

This block captures the most recent key code from a keyboard front end and flags it as unread until the processor acknowledges it. Each arriving code is stored as a byte whose low seven bits are the code and whose top bit is a "new key waiting" strobe. Software polls the data address until the strobe is set, reads the code, and then touches the acknowledge address to drop the strobe.

Three push-button levels share the same small register window. They are read at the three addresses just above the acknowledge address. Read data is combinational from the current latch state. A read of the acknowledge address therefore returns the byte as it stood before that access clears the strobe.

Top module: `kbd_latch`

## Requirements
- R1: When `key_valid` is high at a clock edge, the latch becomes `{1'b1, key_code}`. Bit 7 is the strobe and bits 6:0 are the code.
- R2: A read at `DATA_ADDR` returns the latched byte, strobe included, in the same cycle, and leaves the latch unchanged.
- R3: A write at `DATA_ADDR` has no effect on the latch.
- R4: A read or a write at `CLR_ADDR` clears bit 7 of the latch at the next edge, and keeps bits 6:0.
- R5: A read at `CLR_ADDR` returns the latch value from before the clear.
- R6: A read at `CLR_ADDR+1`, `CLR_ADDR+2` and `CLR_ADDR+3` returns button 0, 1 and 2 respectively. The button level appears in bit 7 and bits 6:0 are zero.
- R7: When a key arrives in the same cycle as an access at `CLR_ADDR`, the new key is stored with its strobe set.
- R8: After reset the latch holds 0x00.
- R9: `cpu_hit` is high exactly on reads of the five mapped addresses. Any other read returns 0x00 with `cpu_hit` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_code | input | CODE_W | Code of the arriving key |
| key_valid | input | 1 | One-cycle pulse marking a new key |
| buttons | input | 3 | Push-button levels, bit i is button i |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rdata | output | CODE_W+1 | Read data, valid while `cpu_rd` is high |
| cpu_hit | output | 1 | Read hit one of the mapped addresses |

## Verification
The bench targets the same-cycle collision of a key with an acknowledge access. A design that lets the clear win would lose the key's strobe. It also checks that a read of the acknowledge address shows the strobe still set; a registered or post-clear read path would return it already cleared. Writes at the data address and writes at the acknowledge address are both exercised, since a decoder that reacts only to reads would leave the strobe stuck. A decoder that corrupts the data would overwrite the code. Each button address is probed with distinct button patterns, so that an off-by-one index shows up as a wrong bit 7.

// File: rtl/kbd_latch.sv
module kbd_latch #(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 7,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] key_code,
  input  logic              key_valid,
  input  logic [2:0]        buttons,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [CODE_W:0]   cpu_rdata,
  output logic              cpu_hit
);
  localparam int DW = CODE_W + 1;

  logic [DW-1:0] latch_q;

  wire              clr_hit = (cpu_rd | cpu_wr) && (cpu_addr == CLR_ADDR);
  wire [ADDR_W-1:0] btn_off = cpu_addr - CLR_ADDR;
  wire              btn_sel = (btn_off >= ADDR_W'(1)) && (btn_off <= ADDR_W'(3));
  wire [1:0]        btn_idx = btn_off[1:0] - 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      latch_q <= '0;
    else if (key_valid)
      latch_q <= {1'b1, key_code};
    else if (clr_hit)
      latch_q[DW-1] <= 1'b0;
  end

  always_comb begin
    cpu_rdata = '0;
    cpu_hit   = 1'b0;
    if (cpu_rd) begin
      if (cpu_addr == DATA_ADDR || cpu_addr == CLR_ADDR) begin
        cpu_rdata = latch_q;
        cpu_hit   = 1'b1;
      end else if (btn_sel) begin
        cpu_rdata = {buttons[btn_idx], {CODE_W{1'b0}}};
        cpu_hit   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/kbd_latch_chk.sv
module kbd_latch_chk #(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 7,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] key_code,
  input logic              key_valid,
  input logic [2:0]        buttons,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [CODE_W:0]   cpu_rdata,
  input logic              cpu_hit,
  input logic [CODE_W:0]   latch
);
  wire clr_acc = (cpu_rd | cpu_wr) && (cpu_addr == CLR_ADDR);

  assert_key_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> latch == {1'b1, $past(key_code)});

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_valid && !clr_acc) |=> $stable(latch));

  assert_strobe_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc && !key_valid) |=> !latch[CODE_W] && latch[CODE_W-1:0] == $past(latch[CODE_W-1:0]));

  assert_key_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc && key_valid) |=> latch[CODE_W]);

  assert_btn0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == CLR_ADDR + ADDR_W'(1)) |-> cpu_rdata == {buttons[0], {CODE_W{1'b0}}});

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hit |-> cpu_rdata == '0);
endmodule

bind kbd_latch kbd_latch_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .DATA_ADDR(DATA_ADDR), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_valid(key_valid),
  .buttons(buttons), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .latch(latch_q)
);

// File: tb/sim_kbd_latch.sv
module sim_kbd_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] key_code = '0;
  logic       key_valid = 1'b0;
  logic [2:0] buttons = '0;
  logic [7:0] cpu_addr = '0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_rdata;
  logic       cpu_hit;

  int checks = 0;
  int fails = 0;
  logic [7:0] mdl = 8'h00;

  localparam logic [7:0] DA = 8'h00;
  localparam logic [7:0] CA = 8'h10;

  always #4 clk = ~clk;

  kbd_latch u0 (
    .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_valid(key_valid),
    .buttons(buttons), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit)
  );

  function automatic logic [8:0] expect_rd(input logic [7:0] a);
    int off;
    off = int'(a) - int'(CA);
    if (a == DA || a == CA) return {1'b1, mdl};
    if (off >= 1 && off <= 3) return {1'b1, buttons[off-1], 7'b0};
    return 9'h000;
  endfunction

  task automatic step(input logic [7:0] a, input logic r, input logic w,
                      input logic kv, input logic [6:0] c, input string req);
    logic [8:0] e;
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w; key_valid = kv; key_code = c;
    #1;
    if (r) begin
      e = expect_rd(a);
      checks++;
      if ({cpu_hit, cpu_rdata} !== e) begin
        fails++;
        $display("FAIL %s addr=%h got hit=%b data=%h exp hit=%b data=%h",
                 req, a, cpu_hit, cpu_rdata, e[8], e[7:0]);
      end
    end
    @(posedge clk);
    if (kv) mdl = {1'b1, c};
    else if ((r | w) && a == CA) mdl[7] = 1'b0;
    #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0; key_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(DA, 1, 0, 0, 0, "R8 reset value");
    step(DA, 1, 0, 1, 7'h41, "R2 read before key");
    step(DA, 1, 0, 0, 0, "R1 key with strobe");
    step(DA, 1, 0, 0, 0, "R2 repeat read unchanged");
    step(DA, 0, 1, 0, 0, "R3 write to data");
    step(DA, 1, 0, 0, 0, "R3 latch after data write");
    step(CA, 1, 0, 0, 0, "R5 clear read returns old");
    step(DA, 1, 0, 0, 0, "R4 strobe cleared by read");
    step(DA, 0, 0, 1, 7'h5a, "R1 second key");
    step(CA, 0, 1, 0, 0, "R4 clear by write");
    step(DA, 1, 0, 0, 0, "R4 strobe cleared by write");
    step(CA, 1, 0, 1, 7'h33, "R7 key with clear read");
    step(DA, 1, 0, 0, 0, "R7 key wins strobe set");
    step(CA, 0, 1, 1, 7'h7f, "R7 key with clear write");
    step(DA, 1, 0, 0, 0, "R7 key wins over write");
    step(CA, 1, 0, 0, 0, "R5 pre-clear value again");
    step(CA, 1, 0, 0, 0, "R5 already clear");
    for (int p = 0; p < 8; p++) begin
      buttons = 3'(p);
      step(CA + 8'd1, 1, 0, 0, 0, "R6 button 0");
      step(CA + 8'd2, 1, 0, 0, 0, "R6 button 1");
      step(CA + 8'd3, 1, 0, 0, 0, "R6 button 2");
    end
    step(CA + 8'd4, 1, 0, 0, 0, "R9 unmapped above buttons");
    step(8'h0f, 1, 0, 0, 0, "R9 unmapped below clear");
    step(8'h01, 1, 0, 0, 0, "R9 unmapped near data");
    step(CA + 8'd1, 0, 1, 1, 7'h12, "R3 button write ignored");
    step(DA, 1, 0, 0, 0, "R1 key after button write");
    for (int k = 0; k < 16; k++) begin
      step(DA, 1, 0, 1, 7'(k * 9 + 3), "R1 key stream");
      step(CA, 1, 0, 0, 0, "R5 stream clear read");
    end
    step(DA, 1, 0, 0, 0, "R2 final");
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    mdl = 8'h00;
    #1 rst_n = 1'b1;
    step(DA, 1, 0, 0, 0, "R8 value after second reset");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule